// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block models a synchronous static RAM whose bus never needs an idle cycle when it changes direction. Address and control are sampled on each rising clock edge. Read data leaves a small internal array and drives the shared data bus through no output register, in the cycle that follows the address cycle. Write data is taken from the same bus one cycle after its address, so read and write data phases line up. Reads, writes and deselects can follow one another in any order.

A one-stage control pipeline holds the captured operation, address and byte-lane mask for the data phase. The pipeline drives the tristate control and carries the delayed write into the array. A held clock enable freezes that stage. Output enable acts only on the bus drivers. The array has byte lanes of configurable width. By default it holds 256 words of four 9-bit lanes.

Top module: `zbt_ft_sram`

## Requirements
- R1: While reset is asserted and after it is released, until a read's data phase, the block does not drive `data_io`.
- R2: An access is loaded only on an edge where `clk_en_ni`=0 and `load_ni`=0, and the chip is selected (`sel_a_ni`=0, `sel_b_ni`=0 and `sel_c_i`=1). Any other enable combination on such an edge is a deselect. A deselect writes nothing, and the bus is released in the cycle that follows it.
- R3: When a load has `read_i`=1, the word at the captured address drives `data_io` during the next cycle, provided `out_en_ni`=0.
- R4: When a load has `read_i`=0, the value on `data_io` is written to the captured address at the next edge with `clk_en_ni`=0. The block does not drive the bus during that data phase.
- R5: Lane i covers bits [LANE_W*i +: LANE_W], and the default is 9-bit lanes. The lane is written only if bit i of `lane_we_ni`, captured with the address, is 0. Lanes whose bit is 1 keep their old contents.
- R6: `out_en_ni`=1 releases the bus at once. It neither cancels nor delays a read, and the data reappears as soon as `out_en_ni` returns to 0 within that data phase.
- R7: An edge with `clk_en_ni`=1 changes no state. The bus keeps its drive or release. A pending write commits at the next enabled edge.
- R8: A read loaded on the same edge that commits a write to the same address returns the newly written lanes.
- R9: An enabled edge with `load_ni`=1 starts no access, whatever the values of `read_i`, `addr_i` and `lane_we_ni`. The bus is released in the following cycle.
- R10: Reads and writes issued on consecutive edges each complete their data phase with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low |
| load_ni | input | 1 | Low: load a new access |
| read_i | input | 1 | 1 = read, 0 = write |
| sel_a_ni | input | 1 | Chip select, active low |
| sel_b_ni | input | 1 | Chip select, active low |
| sel_c_i | input | 1 | Chip select, active high |
| lane_we_ni | input | LANES | Per-lane write enable, active low |
| out_en_ni | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | ADDR_W | Word address |
| data_io | inout | LANE_W*LANES | Bidirectional data bus |

## Verification
The hardest case to reach is a pending write or read held across disabled clock edges. The data phase must then stretch without losing the bus value or the operation. The bench issues a write, freezes the clock enable for several cycles and keeps the write data on the bus. It then loads a read of the same address and freezes again, checking that the read data stays on the bus through the frozen cycles. A write followed directly by a read of the same address exercises the same-edge ordering in the array.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_ni,
  input  logic              load_ni,
  input  logic              read_i,
  input  logic              sel_a_ni,
  input  logic              sel_b_ni,
  input  logic              sel_c_i,
  input  logic [LANES-1:0]  lane_we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  lane_o,
  output logic              commit_o
);
  logic selected;
  op_e  op_q;

  assign selected = !sel_a_ni && !sel_b_ni && sel_c_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      addr_o <= '0;
      lane_o <= '1;
    end else if (!clk_en_ni) begin
      if (!load_ni && selected) begin
        op_q   <= read_i ? OP_RD : OP_WR;
        addr_o <= addr_i;
        lane_o <= lane_we_ni;
      end else begin
        op_q <= OP_IDLE;
      end
    end
  end

  assign op_o     = op_q;
  // delayed write lands on the edge that closes its data phase
  assign commit_o = !clk_en_ni && (op_q == OP_WR);
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        lane_we_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANE_W*LANES-1:0] wdata_i,
  output logic [LANE_W*LANES-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && !lane_we_ni[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    // asynchronous lookup: flow-through read sees writes from the prior edge
    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_ni,
  input  logic                    load_ni,
  input  logic                    read_i,
  input  logic                    sel_a_ni,
  input  logic                    sel_b_ni,
  input  logic                    sel_c_i,
  input  logic [LANES-1:0]        lane_we_ni,
  input  logic                    out_en_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  inout  wire  [LANE_W*LANES-1:0] data_io
);
  localparam int DATA_W = LANE_W * LANES;

  op_e               op;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lane_q;
  logic              commit;
  logic [DATA_W-1:0] rdata;
  logic              bus_drv;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clk_en_ni  (clk_en_ni),
    .load_ni    (load_ni),
    .read_i     (read_i),
    .sel_a_ni   (sel_a_ni),
    .sel_b_ni   (sel_b_ni),
    .sel_c_i    (sel_c_i),
    .lane_we_ni (lane_we_ni),
    .addr_i     (addr_i),
    .op_o       (op),
    .addr_o     (addr_q),
    .lane_o     (lane_q),
    .commit_o   (commit)
  );

  zbt_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk_i      (clk_i),
    .we_i       (commit),
    .lane_we_ni (lane_q),
    .addr_i     (addr_q),
    .wdata_i    (data_io),
    .rdata_o    (rdata)
  );

  assign bus_drv = (op == OP_RD) && !out_en_ni;
  assign data_io = bus_drv ? rdata : 'z;
endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_en_ni,
  input logic load_ni,
  input logic read_i,
  input logic sel_a_ni,
  input logic sel_b_ni,
  input logic sel_c_i,
  input logic out_en_ni,
  input logic bus_drv
);
  logic sel_ok;
  assign sel_ok = !sel_a_ni && !sel_b_ni && sel_c_i;

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_release_chk: assert (!bus_drv);
  end

  // R2
  desel_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !load_ni && !sel_ok) |=> !bus_drv);

  // R3
  read_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !load_ni && sel_ok && read_i) |=> (bus_drv || out_en_ni));

  // R4
  write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !load_ni && sel_ok && !read_i) |=> !bus_drv);

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> ($stable(out_en_ni) -> $stable(bus_drv)));

  // R9
  advance_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && load_ni) |=> !bus_drv);
endmodule

bind zbt_ft_sram zbt_ft_sram_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_en_ni (clk_en_ni),
  .load_ni   (load_ni),
  .read_i    (read_i),
  .sel_a_ni  (sel_a_ni),
  .sel_b_ni  (sel_b_ni),
  .sel_c_i   (sel_c_i),
  .out_en_ni (out_en_ni),
  .bus_drv   (bus_drv)
);

// File: tb/tb_zbt_ft_sram.sv
`timescale 1ns/1ps
module tb_zbt_ft_sram;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam int NL = 4;
  localparam int DW = LW * NL;
  localparam logic [DW-1:0] ONES = '1;
  localparam int K_NONE = 0, K_RD = 1, K_WR = 2, K_ADV = 3;

  logic clk = 0, rst_n = 0;
  logic clk_en_n = 1, load_n = 1, rd = 1;
  logic sel_a_n = 1, sel_b_n = 1, sel_c = 0, oe_n = 1;
  logic [NL-1:0] lane_n = '1;
  logic [AW-1:0] addr = '0;
  logic tb_en = 0;
  logic [DW-1:0] tb_dat = '0;
  wire  [DW-1:0] dq;

  assign dq = tb_en ? tb_dat : 'z;
  for (genvar g = 0; g < DW; g++) begin : g_pu
    pullup pu (dq[g]);
  end

  zbt_ft_sram dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_ni(clk_en_n), .load_ni(load_n),
    .read_i(rd), .sel_a_ni(sel_a_n), .sel_b_ni(sel_b_n), .sel_c_i(sel_c),
    .lane_we_ni(lane_n), .out_en_ni(oe_n), .addr_i(addr), .data_io(dq)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] shadow [1<<AW];
  int p_kind = K_NONE;
  logic [AW-1:0] p_addr;
  logic [NL-1:0] p_bw;
  logic [DW-1:0] p_dat;
  string p_req = "R1";

  function automatic logic [DW-1:0] mk(input int s);
    logic [31:0] h;
    h = 32'(s) * 32'h9E37_79B1 + 32'h1234_5677;
    return {1'b0, 3'(s), h};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic phase_chk(input logic oe, input string req);
    if (p_kind == K_RD && !oe) chk(dq == shadow[p_addr], req, dq, shadow[p_addr]);
    else if (p_kind != K_WR) chk(dq == ONES, req, dq, ONES);
  endtask

  task automatic issue(input int kind, input logic [AW-1:0] a, input logic [NL-1:0] bw,
                       input logic [DW-1:0] wd, input int ce_bad, input logic oe,
                       input string req);
    @(negedge clk);
    clk_en_n = 0; load_n = (kind == K_ADV); rd = (kind == K_RD);
    addr = a; lane_n = bw; oe_n = oe;
    sel_a_n = (ce_bad == 1); sel_b_n = (ce_bad == 2); sel_c = (ce_bad != 3);
    tb_en = (p_kind == K_WR); tb_dat = p_dat;
    #1;
    phase_chk(oe, p_req);
    if (p_kind == K_WR)
      for (int i = 0; i < NL; i++)
        if (!p_bw[i]) shadow[p_addr][i*LW +: LW] = p_dat[i*LW +: LW];
    p_kind = ((kind == K_RD || kind == K_WR) && ce_bad == 0) ? kind : K_NONE;
    p_addr = a; p_bw = bw; p_dat = wd; p_req = req;
  endtask

  task automatic stall(input logic oe, input string req);
    @(negedge clk);
    clk_en_n = 1; addr = ~addr; rd = ~rd; lane_n = ~lane_n; load_n = 0; oe_n = oe;
    #1;
    phase_chk(oe, req);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] bw,
                    input logic [DW-1:0] d, input string req);
    issue(K_WR, a, bw, d, 0, 0, req);
  endtask
  task automatic rdq(input logic [AW-1:0] a, input string req);
    issue(K_RD, a, '1, '0, 0, 0, req);
  endtask
  task automatic desel(input string req);
    issue(K_NONE, 8'hEE, '0, '0, 1, 0, req);
  endtask

  task automatic t_reset;
    repeat (3) begin
      @(negedge clk); #1;
      chk(dq == ONES, "R1", dq, ONES);
    end
    rst_n = 1;
    @(negedge clk); #1;
    chk(dq == ONES, "R1", dq, ONES);
  endtask

  task automatic t_fill;
    for (int a = 0; a < (1 << AW); a++) wr(AW'(a), '0, mk(a + 7), "R4");
    desel("R4");
  endtask

  task automatic t_read;
    for (int a = 0; a < 16; a++) rdq(AW'(a * 13), "R3");
    desel("R3");
  endtask

  task automatic t_mixed;
    wr(8'h10, 4'b0000, mk(500), "R4");
    rdq(8'h10, "R8");
    wr(8'h11, 4'b0000, mk(501), "R10");
    rdq(8'h10, "R10");
    rdq(8'h11, "R10");
    wr(8'h11, 4'b1100, mk(502), "R10");
    rdq(8'h11, "R8");
    wr(8'h12, 4'b0000, mk(503), "R10");
    rdq(8'h12, "R10");
    desel("R10");
  endtask

  task automatic t_desel;
    desel("R2"); desel("R2");
    rdq(8'h05, "R3"); desel("R2");
    rdq(8'h06, "R3"); desel("R2"); desel("R2");
    wr(8'h07, 4'b0000, mk(600), "R4"); desel("R2");
    rdq(8'h07, "R10"); desel("R2"); desel("R2");
  endtask

  task automatic t_chip_en;
    for (int b = 1; b <= 3; b++) begin
      issue(K_WR, AW'(8'h20 + b), '0, mk(900 + b), b, 0, "R2");
      issue(K_RD, AW'(8'h20 + b), '1, '0, b, 0, "R2");
      desel("R2");
    end
    for (int b = 1; b <= 3; b++) rdq(AW'(8'h20 + b), "R2");
    desel("R2");
  endtask

  task automatic t_bytes;
    wr(8'h60, 4'b0000, mk(700), "R5");
    wr(8'h60, 4'b1110, mk(701), "R5");
    rdq(8'h60, "R5");
    wr(8'h60, 4'b0101, mk(702), "R5");
    rdq(8'h60, "R5");
    wr(8'h60, 4'b1111, mk(703), "R5");
    rdq(8'h60, "R5");
    wr(8'h60, 4'b0111, mk(704), "R5");
    desel("R5");
    rdq(8'h60, "R5");
    desel("R5");
  endtask

  task automatic t_stall;
    wr(8'h40, 4'b0000, mk(800), "R7");
    stall(0, "R7"); stall(0, "R7");
    rdq(8'h40, "R7");
    stall(0, "R7"); stall(0, "R7");
    desel("R7");
    stall(0, "R7");
    rdq(8'h41, "R7");
    desel("R7");
  endtask

  task automatic t_oe;
    rdq(8'h50, "R6");
    stall(1, "R6");
    stall(0, "R6");
    issue(K_RD, 8'h51, '1, '0, 0, 1, "R6");
    desel("R6");
  endtask

  task automatic t_adv;
    issue(K_ADV, 8'h30, 4'b0000, mk(950), 0, 0, "R9");
    rdq(8'h30, "R9");
    issue(K_ADV, 8'h31, 4'b0000, '0, 0, 0, "R9");
    desel("R9");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 1'b1, 1'b0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_fill;
    t_read;
    t_mixed;
    t_desel;
    t_chip_en;
    t_bytes;
    t_stall;
    t_oe;
    t_adv;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule